// File: doc/BRIEF.md
# Multi-Width Load Age Tracker with Quad-Word and Fine Tables

This block decides whether an executing store has overtaken a younger load that touched the same memory. Executed loads are recorded by age in two direct-indexed tables. No address is compared associatively. The main table has one entry per hashed quad-word (8 bytes). Each entry holds the age of the youngest load seen there and the access width at which that quad-word is currently tracked. The fine table holds further ages for quad-words that are tracked at a width below eight bytes. It is indexed by the byte address shifted right to that width.

A request is a load or a store. It carries a byte address, an access width and an age. An age is a 2-bit generation prefix followed by a reorder-buffer index. Loads only update state. Each store produces one result, which says whether a replay is needed. The tracking width of a quad-word can only grow. When it grows, the age written to the fine table is the youngest age already recorded for the whole quad-word. A store therefore needs exactly one main read and at most one fine read, and the answer stays conservative.

A controller sequences each request through four states. ST_IDLE accepts a request. ST_MAIN reads the main entry and, for a load, writes it back. ST_SIDE reads the fine entry and, for a load, writes it back. ST_DONE presents a store's result for one cycle. The transitions are named as follows. ACCEPT goes from ST_IDLE to ST_MAIN. MAIN_TO_SIDE is taken by a load below quad width or by a store that the fine table must decide. MAIN_TO_DONE is taken by a store that the main entry decides. MAIN_TO_IDLE is taken by a load tracked at quad width. SIDE_TO_DONE is taken by a store. SIDE_TO_IDLE is taken by a load. DONE_TO_IDLE always follows ST_DONE.

Top module: `qword_order_tracker`

## Requirements
- R1: After reset every entry of both tables is invalid, req_ready is high, and a store of any width to any address returns done_replay = 0.
- R2: Ages are {prefix[1:0], id}. Prefix 0 marks an invalid age. Among prefixes 1, 2 and 3 the order is cyclic: 2 is newer than 1, 3 is newer than 2, and 1 is newer than 3. Under an equal prefix, a larger id is newer.
- R3: Widths are encoded 00 = 1 byte, 01 = 2 bytes, 10 = 4 bytes and 11 = 8 bytes. The main index is address bits [3 +: log2(MAIN_DEPTH)]. The fine index is the low log2(SIDE_DEPTH) bits of the address shifted right by the tracked width code.
- R4: A load to an invalid main entry stores its own age and its own width there.
- R5: A load to a valid main entry leaves the newer of its own age and the stored age in the entry.
- R6: When the entry width is at least the load width, the width is kept and the load is handled at the entry width. This includes indexing the fine table at that width.
- R7: When the entry width is below the load width, the width is raised to the load width. A load tracked at quad width does not touch the fine table.
- R8: The age a load writes to the fine table is the newer of its own age and the age held in the main entry.
- R9: A store newer than the main entry's age, or a store to an invalid main entry, gets done_replay = 0.
- R10: When a store is not newer than the main age and its width is at most the entry width, it is looked up at the entry width. If the entry width is 8 bytes, the result is replay. Otherwise the result is replay exactly when the fine entry is valid and newer than the store.
- R11: A store wider than the entry width, and not newer than the main age, gets done_replay = 1 whatever the fine table holds.
- R12: A fine-table write keeps the newer of the stored age and the incoming age. An invalid fine entry takes the incoming age.
- R13: req_ready is high only in ST_IDLE. Each store produces exactly one done_valid pulse, two or three cycles after acceptance. A load produces none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted on this edge when high together with req_valid |
| req_is_store | input | 1 | 1 = store check, 0 = load record |
| req_addr | input | ADDR_W | Byte address |
| req_width | input | 2 | Access width code |
| req_age | input | ROB_ID_W+2 | Age: prefix and reorder-buffer index |
| done_valid | output | 1 | Store result present |
| done_replay | output | 1 | Store has overtaken a newer recorded load |

## Verification
Directed sequences exercise the cyclic prefix order and widths that grow from a byte to a word and then to a quad-word. Stores are placed at the main-decided boundary (newer, wider, quad) and at the fine-decided boundary (fine entry valid or empty, newer or older). Stores whose fine slot is shared with another quad-word show that a fine entry keeps its newest age and is not overwritten by an older one. A long mixed sweep on a 4-entry main and 8-entry fine configuration compares every store result against an arithmetic model of the requirements. It drives all widths, aliasing quad-words and two generations, and checks the ready and done handshake on every request.

// File: rtl/ord_pkg.sv
package ord_pkg;

    typedef enum logic [1:0] {
        W_BYTE = 2'b00,
        W_HALF = 2'b01,
        W_WORD = 2'b10,
        W_QUAD = 2'b11
    } width_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_MAIN = 2'b01,
        ST_SIDE = 2'b10,
        ST_DONE = 2'b11
    } trk_state_e;

    localparam int WID_W = 2;
    localparam int PFX_W = 2;

    // successor generation: 1 -> 2 -> 3 -> 1
    function automatic logic [1:0] pfx_next(input logic [1:0] p);
        logic [1:0] r;
        case (p)
            2'd1:    r = 2'd2;
            2'd2:    r = 2'd3;
            default: r = 2'd1;
        endcase
        return r;
    endfunction

    // true when age a is strictly newer than age b; prefix 0 is invalid
    function automatic logic age_newer(input logic [1:0] pa, input logic [31:0] ia,
                                       input logic [1:0] pb, input logic [31:0] ib);
        logic r;
        if (pa == 2'd0)      r = 1'b0;
        else if (pb == 2'd0) r = 1'b1;
        else if (pa == pb)   r = (ia > ib);
        else                 r = (pa == pfx_next(pb));
        return r;
    endfunction

endpackage

// File: rtl/ord_age_table.sv
module ord_age_table #(
    parameter int DEPTH  = 512,
    parameter int DATA_W = 11,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data
);

    logic [DATA_W-1:0] ent_q [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_ent
        always_ff @(posedge clk) begin
            if (!rst_n)
                ent_q[g] <= '0;
            else if (wr_en && (wr_idx == IDX_W'(g)))
                ent_q[g] <= wr_data;
        end
    end

    assign rd_data = ent_q[rd_idx];

endmodule

// File: rtl/ord_ctrl.sv
module ord_ctrl
    import ord_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int ROB_ID_W   = 7,
    parameter int MAIN_IDX_W = 9,
    parameter int SIDE_IDX_W = 7,
    localparam int AGE_W     = ROB_ID_W + PFX_W,
    localparam int MENT_W    = AGE_W + WID_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    output logic                  req_ready,
    input  logic                  req_is_store,
    input  logic [ADDR_W-1:0]     req_addr,
    input  logic [WID_W-1:0]      req_width,
    input  logic [AGE_W-1:0]      req_age,
    output logic [MAIN_IDX_W-1:0] main_idx,
    input  logic [MENT_W-1:0]     main_rd_data,
    output logic                  main_wr_en,
    output logic [MENT_W-1:0]     main_wr_data,
    output logic [SIDE_IDX_W-1:0] side_idx,
    input  logic [AGE_W-1:0]      side_rd_data,
    output logic                  side_wr_en,
    output logic [AGE_W-1:0]      side_wr_data,
    output logic                  done_valid,
    output logic                  done_replay
);

    function automatic logic newer(input logic [AGE_W-1:0] a, input logic [AGE_W-1:0] b);
        return age_newer(a[AGE_W-1 -: PFX_W], 32'(a[ROB_ID_W-1:0]),
                         b[AGE_W-1 -: PFX_W], 32'(b[ROB_ID_W-1:0]));
    endfunction

    trk_state_e           state_q, state_d;
    logic                 op_store_q;
    logic [ADDR_W-1:0]    op_addr_q;
    logic [WID_W-1:0]     op_w_q;
    logic [AGE_W-1:0]     op_age_q;
    logic [WID_W-1:0]     eff_w_q, eff_w_d;
    logic [AGE_W-1:0]     wr_age_q, wr_age_d;
    logic                 replay_q, replay_d;

    // main entry decode
    logic [AGE_W-1:0]     m_age;
    logic [WID_W-1:0]     m_w;
    logic                 m_valid;
    logic [WID_W-1:0]     ld_new_w;
    logic [AGE_W-1:0]     ld_new_age;
    logic                 s_valid;
    logic [AGE_W-1:0]     s_merged;
    logic [ADDR_W-1:0]    side_sh;

    assign m_age   = main_rd_data[MENT_W-1 -: AGE_W];
    assign m_w     = main_rd_data[WID_W-1:0];
    assign m_valid = (m_age[AGE_W-1 -: PFX_W] != 2'd0);
    assign s_valid = (side_rd_data[AGE_W-1 -: PFX_W] != 2'd0);

    assign main_idx = op_addr_q[3 +: MAIN_IDX_W];
    assign side_sh  = op_addr_q >> eff_w_q;
    assign side_idx = side_sh[SIDE_IDX_W-1:0];

    always_comb begin
        if (!m_valid) begin
            ld_new_w   = op_w_q;
            ld_new_age = op_age_q;
        end else begin
            ld_new_w   = (m_w >= op_w_q) ? m_w : op_w_q;
            ld_new_age = newer(op_age_q, m_age) ? op_age_q : m_age;
        end
        s_merged = (!s_valid || newer(wr_age_q, side_rd_data)) ? wr_age_q : side_rd_data;
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state and datapath next values
    always_comb begin
        state_d  = state_q;
        eff_w_d  = eff_w_q;
        wr_age_d = wr_age_q;
        replay_d = replay_q;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) state_d = ST_MAIN;                  // ACCEPT
            end
            ST_MAIN: begin
                if (!op_store_q) begin
                    eff_w_d  = ld_new_w;
                    wr_age_d = ld_new_age;
                    state_d  = (ld_new_w == W_QUAD) ? ST_IDLE     // MAIN_TO_IDLE
                                                    : ST_SIDE;    // MAIN_TO_SIDE
                end else if (!m_valid || newer(op_age_q, m_age)) begin
                    replay_d = 1'b0;
                    state_d  = ST_DONE;                            // MAIN_TO_DONE
                end else if (op_w_q > m_w || m_w == W_QUAD) begin
                    replay_d = 1'b1;
                    state_d  = ST_DONE;                            // MAIN_TO_DONE
                end else begin
                    eff_w_d  = m_w;
                    state_d  = ST_SIDE;                            // MAIN_TO_SIDE
                end
            end
            ST_SIDE: begin
                if (op_store_q) begin
                    replay_d = s_valid && newer(side_rd_data, op_age_q);
                    state_d  = ST_DONE;                            // SIDE_TO_DONE
                end else begin
                    state_d  = ST_IDLE;                            // SIDE_TO_IDLE
                end
            end
            ST_DONE: state_d = ST_IDLE;                            // DONE_TO_IDLE
            default: state_d = ST_IDLE;
        endcase
    end

    // captured request and datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_store_q <= 1'b0;
            op_addr_q  <= '0;
            op_w_q     <= '0;
            op_age_q   <= '0;
            eff_w_q    <= '0;
            wr_age_q   <= '0;
            replay_q   <= 1'b0;
        end else begin
            if (state_q == ST_IDLE && req_valid) begin
                op_store_q <= req_is_store;
                op_addr_q  <= req_addr;
                op_w_q     <= req_width;
                op_age_q   <= req_age;
            end
            eff_w_q  <= eff_w_d;
            wr_age_q <= wr_age_d;
            replay_q <= replay_d;
        end
    end

    // outputs
    always_comb begin
        req_ready    = 1'b0;
        main_wr_en   = 1'b0;
        main_wr_data = {ld_new_age, ld_new_w};
        side_wr_en   = 1'b0;
        side_wr_data = s_merged;
        done_valid   = 1'b0;
        done_replay  = 1'b0;
        unique case (state_q)
            ST_IDLE: req_ready  = 1'b1;
            ST_MAIN: main_wr_en = !op_store_q;
            ST_SIDE: side_wr_en = !op_store_q;
            ST_DONE: begin
                done_valid  = 1'b1;
                done_replay = replay_q;
            end
            default: ;
        endcase
    end

    AST_WIDTH_NO_SHRINK: assert property (@(posedge clk) disable iff (!rst_n)
        main_wr_en && m_valid |-> main_wr_data[WID_W-1:0] >= m_w); // R7
    AST_MAIN_AGE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        main_wr_en && m_valid |-> !newer(m_age, main_wr_data[MENT_W-1 -: AGE_W])); // R5
    AST_SIDE_QUAD_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
        side_wr_en |-> eff_w_q != W_QUAD); // R7
    AST_SIDE_AGE_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        side_wr_en |-> side_wr_data[AGE_W-1 -: PFX_W] != 2'd0); // R12
    AST_SIDE_NEVER_OLDER: assert property (@(posedge clk) disable iff (!rst_n)
        side_wr_en && s_valid |-> !newer(side_rd_data, side_wr_data)); // R12
    AST_DONE_IS_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |-> op_store_q); // R13
    AST_DONE_THEN_READY: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |=> req_ready); // R13
    AST_YOUNG_STORE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_MAIN && op_store_q && m_valid && newer(op_age_q, m_age)
        |=> done_valid && !done_replay); // R9
    AST_WIDE_STORE_REPLAY: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_MAIN && op_store_q && m_valid && !newer(op_age_q, m_age) && op_w_q > m_w
        |=> done_valid && done_replay); // R11

endmodule

// File: rtl/qword_order_tracker.sv
module qword_order_tracker
    import ord_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int ROB_ID_W   = 7,
    parameter int MAIN_DEPTH = 512,
    parameter int SIDE_DEPTH = 128,
    localparam int AGE_W      = ROB_ID_W + PFX_W,
    localparam int MENT_W     = AGE_W + WID_W,
    localparam int MAIN_IDX_W = $clog2(MAIN_DEPTH),
    localparam int SIDE_IDX_W = $clog2(SIDE_DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_is_store,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_width,
    input  logic [AGE_W-1:0]  req_age,
    output logic              done_valid,
    output logic              done_replay
);

    logic [MAIN_IDX_W-1:0] main_idx;
    logic [MENT_W-1:0]     main_rd_data, main_wr_data;
    logic                  main_wr_en;
    logic [SIDE_IDX_W-1:0] side_idx;
    logic [AGE_W-1:0]      side_rd_data, side_wr_data;
    logic                  side_wr_en;

    ord_ctrl #(
        .ADDR_W    (ADDR_W),
        .ROB_ID_W  (ROB_ID_W),
        .MAIN_IDX_W(MAIN_IDX_W),
        .SIDE_IDX_W(SIDE_IDX_W)
    ) ctrl_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_ready   (req_ready),
        .req_is_store(req_is_store),
        .req_addr    (req_addr),
        .req_width   (req_width),
        .req_age     (req_age),
        .main_idx    (main_idx),
        .main_rd_data(main_rd_data),
        .main_wr_en  (main_wr_en),
        .main_wr_data(main_wr_data),
        .side_idx    (side_idx),
        .side_rd_data(side_rd_data),
        .side_wr_en  (side_wr_en),
        .side_wr_data(side_wr_data),
        .done_valid  (done_valid),
        .done_replay (done_replay)
    );

    ord_age_table #(.DEPTH(MAIN_DEPTH), .DATA_W(MENT_W)) main_tbl_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_idx (main_idx),
        .rd_data(main_rd_data),
        .wr_en  (main_wr_en),
        .wr_idx (main_idx),
        .wr_data(main_wr_data)
    );

    ord_age_table #(.DEPTH(SIDE_DEPTH), .DATA_W(AGE_W)) side_tbl_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_idx (side_idx),
        .rd_data(side_rd_data),
        .wr_en  (side_wr_en),
        .wr_idx (side_idx),
        .wr_data(side_wr_data)
    );

endmodule

// File: tb/qword_order_tracker_tb_top.sv
module qword_order_tracker_tb_top;

    localparam int AW = 8;
    localparam int RW = 3;
    localparam int GW = RW + 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic          req_is_store = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [1:0]    req_width = '0;
    logic [GW-1:0] req_age = '0;
    logic          done_valid, done_replay;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    // bench-side model of the requirements
    bit [GW-1:0] mdl_m_age [4];
    bit [1:0]    mdl_m_w   [4];
    bit [GW-1:0] mdl_s_age [8];

    qword_order_tracker #(.ADDR_W(AW), .ROB_ID_W(RW), .MAIN_DEPTH(4), .SIDE_DEPTH(8)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_is_store(req_is_store), .req_addr(req_addr), .req_width(req_width),
        .req_age(req_age), .done_valid(done_valid), .done_replay(done_replay));

    always #2 clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            checks++; errors++;
            $display("FAIL watchdog: run hung (actual cycles %0d expected < 150000)", cyc);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // R2 cyclic generation order
    function automatic bit newer(bit [GW-1:0] a, bit [GW-1:0] b);
        bit [1:0] pa = a[GW-1 -: 2];
        bit [1:0] pb = b[GW-1 -: 2];
        if (pa == 0) return 0;
        if (pb == 0) return 1;
        if (pa == pb) return a[RW-1:0] > b[RW-1:0];
        return (pa == 1 && pb == 3) || (pa == 2 && pb == 1) || (pa == 3 && pb == 2);
    endfunction

    function automatic bit [GW-1:0] mk(int p, int id);
        return GW'((p << RW) | id);
    endfunction

    function automatic void mdl_clear();
        for (int i = 0; i < 4; i++) begin mdl_m_age[i] = '0; mdl_m_w[i] = '0; end
        for (int i = 0; i < 8; i++) mdl_s_age[i] = '0;
    endfunction

    function automatic void mdl_load(bit [AW-1:0] a, bit [1:0] w, bit [GW-1:0] g);
        int mi = int'(a[4:3]);
        bit [1:0] nw; bit [GW-1:0] na; int si;
        if (mdl_m_age[mi][GW-1 -: 2] == 0) begin nw = w; na = g; end
        else begin
            nw = (mdl_m_w[mi] >= w) ? mdl_m_w[mi] : w;
            na = newer(g, mdl_m_age[mi]) ? g : mdl_m_age[mi];
        end
        mdl_m_age[mi] = na; mdl_m_w[mi] = nw;
        if (nw != 2'b11) begin
            si = int'((a >> nw) & 8'h7);
            if (mdl_s_age[si][GW-1 -: 2] == 0 || newer(na, mdl_s_age[si])) mdl_s_age[si] = na;
        end
    endfunction

    function automatic bit mdl_store(bit [AW-1:0] a, bit [1:0] w, bit [GW-1:0] g);
        int mi = int'(a[4:3]);
        int si;
        if (mdl_m_age[mi][GW-1 -: 2] == 0 || newer(g, mdl_m_age[mi])) return 0;
        if (w > mdl_m_w[mi] || mdl_m_w[mi] == 2'b11) return 1;
        si = int'((a >> mdl_m_w[mi]) & 8'h7);
        return mdl_s_age[si][GW-1 -: 2] != 0 && newer(mdl_s_age[si], g);
    endfunction

    task automatic check(bit cond, string req, int act, int exp);
        checks++;
        if (!cond) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0; req_valid = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        mdl_clear();
        @(negedge clk);
    endtask

    // issue one request; for a store compare against exp_rep
    task automatic issue(bit st, bit [AW-1:0] a, bit [1:0] w, bit [GW-1:0] g,
                         bit exp_rep, string req);
        int pulses = 0;
        bit got = 0;
        int lat = 0;
        req_valid = 1'b1; req_is_store = st; req_addr = a; req_width = w; req_age = g;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        if (req_ready) check(0, "R13 busy after accept", 1, 0);
        while (!req_ready) begin
            lat++;
            if (done_valid) begin pulses++; got = done_replay; end
            @(negedge clk);
        end
        if (st) begin
            check(pulses == 1, "R13 store pulse count", pulses, 1);
            check(got == exp_rep, req, int'(got), int'(exp_rep));
        end else begin
            check(pulses == 0, "R13 load pulse count", pulses, 0);
        end
    endtask

    task automatic ld(bit [AW-1:0] a, bit [1:0] w, bit [GW-1:0] g);
        issue(0, a, w, g, 0, "load");
        mdl_load(a, w, g);
    endtask

    task automatic st(bit [AW-1:0] a, bit [1:0] w, bit [GW-1:0] g, bit exp, string req);
        check(mdl_store(a, w, g) == exp, {req, " model"}, int'(mdl_store(a, w, g)), int'(exp));
        issue(1, a, w, g, exp, req);
    endtask

    initial begin
        do_reset();
        // R1 reset state
        check(req_ready == 1'b1, "R1 ready after reset", int'(req_ready), 1);
        check(done_valid == 1'b0, "R1 no result after reset", int'(done_valid), 0);
        for (int a = 0; a < 32; a += 3)
            for (int w = 0; w < 4; w++) st(AW'(a), 2'(w), mk(1, 0), 0, "R1 empty store");

        // R2 cyclic prefix order, R3 quad load main only
        do_reset();
        ld(8'h00, 2'b11, mk(2, 0));
        st(8'h00, 2'b11, mk(1, 7), 1, "R2 prefix2 newer than 1");
        st(8'h05, 2'b00, mk(3, 0), 0, "R2 prefix3 newer than 2");
        ld(8'h08, 2'b11, mk(1, 0));
        st(8'h08, 2'b11, mk(3, 5), 1, "R2 prefix1 newer than 3");
        ld(8'h10, 2'b11, mk(1, 4));
        st(8'h10, 2'b00, mk(1, 3), 1, "R3 quad tracked byte store");
        st(8'h17, 2'b01, mk(1, 5), 0, "R9 newer store");

        // R4/R6/R10/R11 byte tracking
        do_reset();
        ld(8'h10, 2'b00, mk(1, 2));
        st(8'h14, 2'b10, mk(1, 1), 1, "R11 wider store replays");
        st(8'h15, 2'b00, mk(1, 1), 0, "R10 empty fine slot");
        st(8'h10, 2'b00, mk(1, 1), 1, "R4 fine slot at byte index");
        st(8'h10, 2'b00, mk(1, 3), 0, "R9 store newer than main");

        // R5/R6/R7/R8 width growth byte->word->quad
        do_reset();
        ld(8'h01, 2'b00, mk(1, 5));
        ld(8'h03, 2'b00, mk(1, 6));
        ld(8'h00, 2'b10, mk(1, 3));
        st(8'h00, 2'b10, mk(1, 4), 1, "R8 raised fine age newest");
        st(8'h01, 2'b00, mk(1, 5), 1, "R6 byte store at word width");
        st(8'h00, 2'b10, mk(1, 6), 0, "R5 main keeps newest");
        ld(8'h02, 2'b00, mk(1, 7));
        st(8'h00, 2'b01, mk(1, 6), 1, "R6 byte load at word width");
        ld(8'h04, 2'b11, mk(1, 1));
        st(8'h04, 2'b00, mk(1, 6), 1, "R7 raised to quad");

        // R12 shared fine slot keeps newest
        do_reset();
        ld(8'h18, 2'b00, mk(1, 6));
        ld(8'h00, 2'b00, mk(1, 7));
        ld(8'h08, 2'b00, mk(1, 4));
        st(8'h18, 2'b00, mk(1, 5), 1, "R12 fine keeps newer age");

        // mixed sweep against the model
        do_reset();
        for (int n = 0; n < 3000; n++) begin
            bit [AW-1:0] a = AW'($urandom_range(0, 63));
            bit [1:0] w = 2'($urandom_range(0, 3));
            bit [GW-1:0] g = mk($urandom_range(1, 2), $urandom_range(0, 7));
            if ($urandom_range(0, 1) == 1) st(a, w, g, mdl_store(a, w, g), "R10 sweep store");
            else ld(a, w, g);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule